// File: doc/BRIEF.md
# Tick-Placed Amplitude Update Channel

This block is one pixel channel of a wide modulator driver. Each column period it holds a pending 10-bit amplitude and an 8-bit delay that were written ahead of time. When the column strobe arrives, the pending pair moves into working registers and a tick counter restarts from zero. The counter advances on every cycle in which the fine delay tick enable is high. On the tick where the counter equals the working delay, the working amplitude is copied to the output register. That output would feed a DAC. The effect is that the edge of the amplitude change is placed at a chosen sub-column position, not at the column boundary.

The whole block runs on one system clock. The fine delay clock arrives as a synchronous one-cycle enable, `fine_tick`. The channel has three states, kept in `phase`:
- `PH_IDLE` is the state after reset, before any column has started.
- `PH_ARMED` means the counter is running and the update is still to come.
- `PH_DONE` means this column's update has been made.

There are three transitions:
- Any state goes to `PH_ARMED` on a column strobe.
- `PH_ARMED` goes to `PH_DONE` on the matching tick.
- Otherwise each state holds.

The column is usually shorter than 256 ticks, so a large delay may never be reached. In that case the output keeps its previous value through the column.

Top module: `tick_placed_amp_channel`

## Requirements
- R1: After reset, `level_out` is 0 and the pending amplitude and pending delay are both 0.
- R2: A cycle with `load_next` high captures `next_level` and `next_delay` as the pending pair. The pending pair does not change the output until a later column strobe. If `load_next` and `col_strobe` are high in the same cycle, the strobe takes the previously pending pair, and the newly loaded pair waits for the following strobe.
- R3: `col_strobe` clears the tick counter to zero and copies the pending pair into the working pair. A `fine_tick` in the same cycle as the strobe is not counted.
- R4: After a strobe, only cycles with `fine_tick` high count as ticks. Cycles with `fine_tick` low neither advance the count nor trigger the update.
- R5: With working delay d, `level_out` takes the working amplitude at the clock edge of the (d+1)-th counted tick after the strobe. A delay of 0 therefore updates on the first tick.
- R6: At most one update happens per column. After the update, further ticks and loads leave `level_out` unchanged until the next strobe.
- R7: If the next strobe arrives before the (d+1)-th tick, `level_out` keeps its previous amplitude through the whole column. The unapplied pair is discarded.
- R8: The full ranges work. Delay 255 updates on the 256th tick, and amplitude 0x3FF is carried unchanged to the output.
- R9: Between reset and the first `col_strobe`, ticks leave `level_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_strobe | input | 1 | One-cycle column start pulse |
| fine_tick | input | 1 | Synchronous enable marking one fine delay tick |
| load_next | input | 1 | Write strobe for the pending amplitude/delay pair |
| next_level | input | 10 | Amplitude for a following column |
| next_delay | input | 8 | Tick delay for a following column |
| level_out | output | 10 | Currently applied amplitude |

## Verification
The bench builds the channel with its default widths: a 10-bit amplitude and an 8-bit delay. At these widths a full 256-tick column fits easily within the run, so the bench reaches the delay-255 boundary and the counter's top value directly. It also runs 200-tick columns with a delay of 250, which exercises the unreached-delay case. Sparse tick patterns, strobes that arrive mid-count, and loads or ticks that coincide with a strobe cover the priority and ordering rules.

// File: rtl/ampch_pkg.sv
package ampch_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;

endpackage

// File: rtl/ampch_stage.sv
module ampch_stage #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_next,
    input  logic          col_strobe,
    input  logic [AW-1:0] next_level,
    input  logic [DW-1:0] next_delay,
    output logic [AW-1:0] work_level,
    output logic [DW-1:0] work_delay
);

    logic [AW-1:0] pend_level;
    logic [DW-1:0] pend_delay;

    // Pending pair: written by software-side loads at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_level <= '0;
            pend_delay <= '0;
        end else if (load_next) begin
            pend_level <= next_level;
            pend_delay <= next_delay;
        end
    end

    // Working pair: refreshed only at the column boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_level <= '0;
            work_delay <= '0;
        end else if (col_strobe) begin
            work_level <= pend_level;
            work_delay <= pend_delay;
        end
    end

    // R2: the pending pair moves only on a load
    a_r2_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_next |=> ($stable(pend_level) && $stable(pend_delay)));

    // R6: the working pair is frozen inside a column
    a_r6_work_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !col_strobe |=> ($stable(work_level) && $stable(work_delay)));

endmodule

// File: rtl/ampch_ticker.sv
module ampch_ticker #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [DW-1:0] count
);

    localparam logic [DW-1:0] CNT_TOP = {DW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance && (count != CNT_TOP)) begin
            count <= count + 1'b1;
        end
    end

    // R3: a strobe leaves the counter at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R4: no tick, no movement
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(count));

endmodule

// File: rtl/ampch_phase.sv
module ampch_phase
    import ampch_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_strobe,
    input  logic          fine_tick,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] work_delay,
    output phase_t        phase,
    output logic          counting,
    output logic          apply
);

    phase_t phase_nx;
    logic   hit;

    assign hit = (count == work_delay);

    always_comb begin
        phase_nx = phase;
        if (col_strobe) begin
            phase_nx = PH_ARMED;
        end else begin
            unique case (phase)
                PH_IDLE:  phase_nx = PH_IDLE;
                PH_ARMED: if (fine_tick && hit) phase_nx = PH_DONE;
                PH_DONE:  phase_nx = PH_DONE;
                default:  phase_nx = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    always_comb begin
        counting = 1'b0;
        apply    = 1'b0;
        unique case (phase)
            PH_IDLE:  ;
            PH_ARMED: begin
                counting = !col_strobe;
                apply    = !col_strobe && fine_tick && hit;
            end
            PH_DONE:  ;
            default:  ;
        endcase
    end

    // R6: a second update needs a new strobe in between
    a_r6_one_apply: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !apply);

    // R3: every strobe arms the channel
    a_r3_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |=> (phase == PH_ARMED));

endmodule

// File: rtl/ampch_level.sv
module ampch_level #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic [AW-1:0] work_level,
    output logic [AW-1:0] level_out
);

    always_ff @(posedge clk) begin
        if (!rst_n)     level_out <= '0;
        else if (apply) level_out <= work_level;
    end

    // R7: without an update the applied amplitude is held
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(level_out));

endmodule

// File: rtl/tick_placed_amp_channel.sv
module tick_placed_amp_channel
    import ampch_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_strobe,
    input  logic          fine_tick,
    input  logic          load_next,
    input  logic [AW-1:0] next_level,
    input  logic [DW-1:0] next_delay,
    output logic [AW-1:0] level_out
);

    logic [AW-1:0] work_level;
    logic [DW-1:0] work_delay;
    logic [DW-1:0] count;
    phase_t        phase;
    logic          counting;
    logic          apply;

    ampch_stage #(.AW(AW), .DW(DW)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_next  (load_next),
        .col_strobe (col_strobe),
        .next_level (next_level),
        .next_delay (next_delay),
        .work_level (work_level),
        .work_delay (work_delay)
    );

    ampch_ticker #(.DW(DW)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (col_strobe),
        .advance (counting && fine_tick),
        .count   (count)
    );

    ampch_phase #(.DW(DW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_strobe (col_strobe),
        .fine_tick  (fine_tick),
        .count      (count),
        .work_delay (work_delay),
        .phase      (phase),
        .counting   (counting),
        .apply      (apply)
    );

    ampch_level #(.AW(AW)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply      (apply),
        .work_level (work_level),
        .level_out  (level_out)
    );

    // R9: nothing moves the output before the first column
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !col_strobe) |=> $stable(level_out));

    // R5: an update carries the working amplitude
    a_r5_apply_value: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (level_out == $past(work_level)));

    // R6: once done, the column is quiet until the next strobe
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !col_strobe) |=> $stable(level_out));

endmodule

// File: tb/tick_placed_amp_channel_test.sv
module tick_placed_amp_channel_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [9:0] exp;
        int         req;
        time        t;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       col_strobe = 1'b0;
    logic       fine_tick = 1'b0;
    logic       load_next = 1'b0;
    logic [9:0] next_level = '0;
    logic [7:0] next_delay = '0;
    logic [9:0] level_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic [9:0] cur = '0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_placed_amp_channel uut (
        .clk(clk), .rst_n(rst_n), .col_strobe(col_strobe),
        .fine_tick(fine_tick), .load_next(load_next),
        .next_level(next_level), .next_delay(next_delay),
        .level_out(level_out)
    );

    // Monitor: compare each expectation after the edge it describes.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && sb[0].t < $time - CLK_PERIOD/2) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (level_out !== e.exp) begin
                    n_bad++;
                    $display("FAIL R%0d: level_out=%h expected=%h at %0t",
                             e.req, level_out, e.exp, $time);
                end
            end
        end
    end

    // Driver step: drives one cycle and queues the output expected after it.
    task automatic step(input logic s, input logic t, input logic ld,
                        input logic [9:0] lv, input logic [7:0] dl,
                        input int req);
        exp_t e;
        @(posedge clk);
        #1;
        col_strobe = s; fine_tick = t; load_next = ld;
        next_level = lv; next_delay = dl;
        e.exp = cur; e.req = req; e.t = $time;
        sb.push_back(e);
    endtask

    task automatic load(input logic [9:0] lv, input logic [7:0] dl, input int req);
        step(1'b0, 1'b0, 1'b1, lv, dl, req);
    endtask

    // One column: strobe, then nticks ticks with gap idle cycles before each.
    // New amplitude lands on tick index d (the (d+1)-th tick).
    task automatic column(input logic [9:0] lv, input int d, input int nticks,
                          input int gap, input int req);
        step(1'b1, 1'b0, 1'b0, '0, '0, req);
        for (int i = 0; i < nticks; i++) begin
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, '0, '0, req);
            if (i == d) cur = lv;
            step(1'b0, 1'b1, 1'b0, '0, '0, req);
        end
    endtask

    task automatic drain();
        step(1'b0, 1'b0, 1'b0, '0, '0, 0);
        wait (sb.size() == 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;  // R1: reset value
        if (level_out !== 10'h000) begin
            n_bad++;
            $display("FAIL R1: level_out=%h expected=000", level_out);
        end

        // R9: ticks before any strobe do nothing
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, '0, '0, 9);
        // R1: pending cleared at reset -> first column applies 0 at tick 0
        column(10'h000, 0, 3, 0, 1);

        // R2: a load alone leaves the output alone
        load(10'h155, 8'd0, 2);
        step(1'b0, 1'b1, 1'b0, '0, '0, 2);
        // R5: delay 0 updates on the first tick
        column(10'h155, 0, 3, 0, 5);

        // R5: delay 5, back-to-back ticks
        load(10'h2AA, 8'd5, 5);
        column(10'h2AA, 5, 9, 0, 5);

        // R4: delay 3 with idle cycles between ticks
        load(10'h0F0, 8'd3, 4);
        column(10'h0F0, 3, 6, 3, 4);

        // R7: delay 250 in a 200-tick column is never reached
        load(10'h3C3, 8'd250, 7);
        column(10'h3C3, 250, 200, 0, 7);

        // R8: delay 255 and full-scale amplitude, 256-tick column
        load(10'h3FF, 8'd255, 8);
        column(10'h3FF, 255, 256, 0, 8);

        // R6: after the update, more ticks and a load do not disturb output
        load(10'h011, 8'd1, 6);
        column(10'h011, 1, 3, 0, 6);
        step(1'b0, 1'b1, 1'b1, 10'h222, 8'd0, 6);
        step(1'b0, 1'b1, 1'b0, '0, '0, 6);
        step(1'b0, 1'b1, 1'b0, '0, '0, 6);

        // R7: mid-count strobe discards the unapplied pair
        load(10'h1E1, 8'd10, 7);
        column(10'h1E1, 99, 0, 0, 7);        // strobe takes 10'h1E1/10
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, '0, '0, 7);
        load(10'h0AB, 8'd2, 7);
        column(10'h0AB, 2, 4, 0, 7);          // restart: update on 3rd tick

        // R3: tick coinciding with strobe is not counted
        load(10'h133, 8'd0, 3);
        step(1'b1, 1'b1, 1'b0, '0, '0, 3);    // strobe+tick: no update
        cur = 10'h133;
        step(1'b0, 1'b1, 1'b0, '0, '0, 3);    // first counted tick applies

        // R2: load on the strobe cycle waits for the next column
        load(10'h044, 8'd0, 2);
        step(1'b1, 1'b0, 1'b1, 10'h388, 8'd1, 2);
        cur = 10'h044;
        step(1'b0, 1'b1, 1'b0, '0, '0, 2);    // old pending applied
        step(1'b0, 1'b1, 1'b0, '0, '0, 2);
        column(10'h388, 1, 3, 1, 2);          // new pair in the next column

        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule